// File: doc/BRIEF.md
# Three-Wire Control Bus Register Bank

This block is a write-only slave on a three-wire control bus made of a mode line, a bus clock and a data line. The bus signals are asynchronous to the block. They are brought into the system clock domain, and a bit is taken on every rising edge of the bus clock. Eight bits make one byte, and the first bit received is the least significant. A byte sent while the mode line is low is an address byte. The address byte names the device, using an identity that a strap input can change. It also names a transfer class, either status or feature. Every byte sent while the mode line is high is a data byte. Each data byte is written to the class that the last address byte chose, for as long as that choice stands.

Status bytes set the system-clock ratio, the serial input format, the mute style and the power state, and one of them carries a soft-reset command. Feature bytes set volume, fine volume, de-emphasis and the mute, silence-participation and inversion flags. The per-channel fields are kept for six channels. A write to one of them goes to the channel that a persistent pointer names, or to every channel when broadcast is on. The bus has no flow control. The block takes each byte whenever it arrives, and it holds no valid/ready handshake at either edge.

Top module: `ctl3w_regbank`

## Requirements
- R1: A byte is framed by eight rising edges of `bus_clk` and taken LSB first. If `bus_mode` is low at the eighth edge, the byte is an address byte.
- R2: Address bits 1:0 choose the class of the data bytes that follow: 00 is feature and 10 is status. With 01 or 11, every data byte is ignored.
- R3: Address bits 7:2 must equal 00010 followed by the value of `addr_sel`. Any other address deselects the block, and the data bytes that follow change nothing.
- R4: A selection stays in force for any number of data bytes. A byte takes effect only after its eighth bit. Count as edge 1 the first `clk` edge that samples `bus_clk` high for that bit. The outputs then show the new value after edge 4.
- R5: A rising edge of `bus_mode` throws away a partly received byte.
- R6: A status byte with bit 7 = 0 and bit 6 = 0 loads `sys_clk_sel` from bits 5:4 (00 = 512, 01 = 384, 10 = 256, 11 = 768 times the sample rate). It loads `in_fmt` from bits 3:1.
- R7: A status byte with bits 7:6 = 10 sets `quick_mute` from bit 1 and `power_on` from bit 0. A status byte with bits 7:6 = 11 is ignored.
- R8: A status byte with bit 7 = 0 and bit 6 = 1 restores the defaults and leaves `sys_clk_sel` and `in_fmt` unchanged. The defaults are: soft mute, power on, volume and fine volume 0, de-emphasis 0, mute off, silence participation on, inversion off.
- R9: A feature byte with bits 7:6 = 00 writes bits 5:0 as the volume code of the target channels. A feature byte with bits 7:6 = 01 writes bits 1:0 as their fine volume.
- R10: A feature byte with bits 7:6 = 10 writes mute (bit 2), silence participation (bit 1) and inversion (bit 0) to the target channels. It writes `deemph` from bits 5:3 only while broadcast is on.
- R11: A feature byte with bits 7:6 = 11 sets broadcast from bit 3 and the pointer from bits 2:0. Pointer code k selects channel k+1, which is slice k of every per-channel output. With broadcast on, every channel is a target.
- R12: With broadcast off and the pointer at 6 or 7, writes to per-channel fields are ignored.
- R13: After `rst_n` the outputs hold the R8 defaults with `sys_clk_sel` = 00 and `in_fmt` = 000. Broadcast starts on and the pointer starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 1 | Bus mode line (low = address phase) |
| bus_clk | input | 1 | Bus bit clock |
| bus_data | input | 1 | Bus data line |
| addr_sel | input | 1 | Strap that picks the low identity bit |
| sys_clk_sel | output | 2 | System-clock ratio code |
| in_fmt | output | 3 | Serial input format code |
| quick_mute | output | 1 | 1 = quick mute, 0 = soft mute |
| power_on | output | 1 | Converter power enable |
| deemph | output | 3 | De-emphasis code |
| vol_flat | output | 36 | Volume code, 6 bits per channel |
| subvol_flat | output | 12 | Fine volume, 2 bits per channel |
| mute_vec | output | 6 | Mute per channel |
| silence_vec | output | 6 | Silence participation per channel |
| invert_vec | output | 6 | Output inversion per channel |

## Verification
Every result is due on the fourth system-clock edge after the first edge that samples the eighth bus-clock rise of a byte. Two of those edges are spent in the synchroniser, one in framing the byte and one in writing the register. The bench drives the bus lines at falling edges. After the eighth rise it waits exactly four rising edges before it updates its behavioural model, and it compares every output with that model at each falling edge. A result that arrives one cycle early or one cycle late is therefore reported.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  typedef enum logic [1:0] {
    XF_FEAT = 2'b00,
    XF_RSV1 = 2'b01,
    XF_STAT = 2'b10,
    XF_RSV3 = 2'b11
  } xfer_e;

  localparam int BYTE_W = 8;
  localparam int PTR_W  = 3;
  localparam logic [4:0] DEV_ID_HI = 5'b00010;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_rise,
  input  logic         bit_val,
  input  logic         mode_lvl,
  input  logic         mode_rise,
  output logic         byte_vld,
  output logic [W-1:0] byte_q,
  output logic         is_addr
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic [W-2:0]  sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sh       <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
      is_addr  <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (mode_rise) begin
        cnt <= '0;
      end else if (bit_rise) begin
        sh <= {bit_val, sh[W-2:1]};
        if (cnt == LAST) begin
          cnt      <= '0;
          byte_vld <= 1'b1;
          byte_q   <= {bit_val, sh};
          is_addr  <= !mode_lvl;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R4: a committed byte always follows a sampled bus clock rise
  a_r4_byte_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(bit_rise));
  // R5: a mode rise never completes a byte
  a_r5_partial_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rise |=> !byte_vld);
endmodule

// File: rtl/ctl3w_chan.sv
module ctl3w_chan #(
  parameter int NCH   = 6,
  parameter int VOL_W = 6,
  parameter int SUB_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restore,
  input  logic [NCH-1:0]     tgt,
  input  logic               we_vol,
  input  logic               we_sub,
  input  logic               we_flg,
  input  logic [VOL_W-1:0]   vol_in,
  input  logic [SUB_W-1:0]   sub_in,
  input  logic               mute_in,
  input  logic               sil_in,
  input  logic               inv_in,
  output logic [NCH*VOL_W-1:0] vol_flat,
  output logic [NCH*SUB_W-1:0] sub_flat,
  output logic [NCH-1:0]     mute_v,
  output logic [NCH-1:0]     sil_v,
  output logic [NCH-1:0]     inv_v
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [VOL_W-1:0] vol_r;
    logic [SUB_W-1:0] sub_r;
    logic mute_r, sil_r, inv_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vol_r  <= '0;
        sub_r  <= '0;
        mute_r <= 1'b0;
        sil_r  <= 1'b1;
        inv_r  <= 1'b0;
      end else if (restore) begin
        vol_r  <= '0;
        sub_r  <= '0;
        mute_r <= 1'b0;
        sil_r  <= 1'b1;
        inv_r  <= 1'b0;
      end else if (tgt[c]) begin
        if (we_vol) vol_r <= vol_in;
        if (we_sub) sub_r <= sub_in;
        if (we_flg) begin
          mute_r <= mute_in;
          sil_r  <= sil_in;
          inv_r  <= inv_in;
        end
      end
    end

    assign vol_flat[c*VOL_W +: VOL_W] = vol_r;
    assign sub_flat[c*SUB_W +: SUB_W] = sub_r;
    assign mute_v[c] = mute_r;
    assign sil_v[c]  = sil_r;
    assign inv_v[c]  = inv_r;
  end

  // R12: a field write with no target channel leaves every channel untouched
  a_r12_no_target_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (we_vol || we_sub || we_flg) && (tgt == '0) && !restore |=>
      $stable(vol_flat) && $stable(sub_flat) && $stable(mute_v) && $stable(sil_v) && $stable(inv_v));
endmodule

// File: rtl/ctl3w_regbank.sv
module ctl3w_regbank
  import ctl3w_pkg::*;
#(
  parameter int NCH   = 6,
  parameter int VOL_W = 6,
  parameter int SUB_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_mode,
  input  logic                 bus_clk,
  input  logic                 bus_data,
  input  logic                 addr_sel,
  output logic [1:0]           sys_clk_sel,
  output logic [2:0]           in_fmt,
  output logic                 quick_mute,
  output logic                 power_on,
  output logic [2:0]           deemph,
  output logic [NCH*VOL_W-1:0] vol_flat,
  output logic [NCH*SUB_W-1:0] subvol_flat,
  output logic [NCH-1:0]       mute_vec,
  output logic [NCH-1:0]       silence_vec,
  output logic [NCH-1:0]       invert_vec
);
  localparam int NLINE = 4;

  logic [NLINE-1:0] line_s;
  logic mode_s, clk_s, data_s, sel_s;
  logic mode_d, clk_d;

  ctl3w_sync #(.N(NLINE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({addr_sel, bus_data, bus_clk, bus_mode}),
    .q     (line_s)
  );
  assign {sel_s, data_s, clk_s, mode_s} = line_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_d <= 1'b0;
      clk_d  <= 1'b0;
    end else begin
      mode_d <= mode_s;
      clk_d  <= clk_s;
    end
  end

  logic              byte_vld, is_addr;
  logic [BYTE_W-1:0] byte_q;

  ctl3w_shift #(.W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_rise  (clk_s && !clk_d),
    .bit_val   (data_s),
    .mode_lvl  (mode_s),
    .mode_rise (mode_s && !mode_d),
    .byte_vld  (byte_vld),
    .byte_q    (byte_q),
    .is_addr   (is_addr)
  );

  // Address and command decode
  logic             selected, all_ch;
  xfer_e            xfer;
  logic [PTR_W-1:0] ptr;
  logic [1:0]       field;
  logic data_byte, stat_cmd, feat_cmd, stat_main, restore;
  logic we_vol, we_sub, we_flg, we_ptr;
  logic [NCH-1:0] tgt;

  assign field     = byte_q[7:6];
  assign data_byte = byte_vld && !is_addr && selected;
  assign stat_cmd  = data_byte && (xfer == XF_STAT);
  assign feat_cmd  = data_byte && (xfer == XF_FEAT);
  assign stat_main = stat_cmd && !byte_q[7];
  assign restore   = stat_main && byte_q[6];
  assign we_vol    = feat_cmd && (field == 2'b00);
  assign we_sub    = feat_cmd && (field == 2'b01);
  assign we_flg    = feat_cmd && (field == 2'b10);
  assign we_ptr    = feat_cmd && (field == 2'b11);

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      tgt[c] = all_ch || (ptr == PTR_W'(c));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selected    <= 1'b0;
      xfer        <= XF_RSV1;
      all_ch      <= 1'b1;
      ptr         <= '0;
      sys_clk_sel <= '0;
      in_fmt      <= '0;
      quick_mute  <= 1'b0;
      power_on    <= 1'b1;
      deemph      <= '0;
    end else begin
      if (byte_vld && is_addr) begin
        selected <= (byte_q[7:2] == {DEV_ID_HI, sel_s});
        xfer     <= xfer_e'(byte_q[1:0]);
      end
      if (stat_main && !byte_q[6]) begin
        sys_clk_sel <= byte_q[5:4];
        in_fmt      <= byte_q[3:1];
      end
      if (stat_cmd && field == 2'b10) begin
        quick_mute <= byte_q[1];
        power_on   <= byte_q[0];
      end else if (restore) begin
        quick_mute <= 1'b0;
        power_on   <= 1'b1;
      end
      if (restore) begin
        deemph <= '0;
      end else if (we_flg && all_ch) begin
        deemph <= byte_q[5:3];
      end
      if (we_ptr) begin
        all_ch <= byte_q[3];
        ptr    <= byte_q[2:0];
      end
    end
  end

  ctl3w_chan #(.NCH(NCH), .VOL_W(VOL_W), .SUB_W(SUB_W)) u_chan (
    .clk      (clk),
    .rst_n    (rst_n),
    .restore  (restore),
    .tgt      (tgt),
    .we_vol   (we_vol),
    .we_sub   (we_sub),
    .we_flg   (we_flg),
    .vol_in   (byte_q[VOL_W-1:0]),
    .sub_in   (byte_q[SUB_W-1:0]),
    .mute_in  (byte_q[2]),
    .sil_in   (byte_q[1]),
    .inv_in   (byte_q[0]),
    .vol_flat (vol_flat),
    .sub_flat (subvol_flat),
    .mute_v   (mute_vec),
    .sil_v    (silence_vec),
    .inv_v    (invert_vec)
  );

  // R3: data bytes while deselected change no output
  a_r3_ignore_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && !is_addr && !selected |=>
      $stable(vol_flat) && $stable(sys_clk_sel) && $stable(power_on) && $stable(deemph));
  // R8: soft reset restores defaults
  a_r8_restore_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> power_on && !quick_mute && (vol_flat == '0) && (deemph == '0) && (&silence_vec));
  // R8: soft reset keeps clock and format settings
  a_r8_keep_clock: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> $stable(sys_clk_sel) && $stable(in_fmt));
  // R7: power bit follows the committed status byte
  a_r7_power_write: assert property (@(posedge clk) disable iff (!rst_n)
    stat_cmd && (field == 2'b10) |=> power_on == $past(byte_q[0]));
endmodule

// File: tb/ctl3w_regbank_tb.sv
module ctl3w_regbank_tb;
  localparam int NCH = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_mode = 1'b1, bus_clk = 1'b0, bus_data = 1'b0, addr_sel = 1'b0;
  logic [1:0] sys_clk_sel;
  logic [2:0] in_fmt, deemph;
  logic quick_mute, power_on;
  logic [NCH*6-1:0] vol_flat;
  logic [NCH*2-1:0] subvol_flat;
  logic [NCH-1:0] mute_vec, silence_vec, invert_vec;

  always #4 clk = ~clk;

  ctl3w_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .bus_clk(bus_clk),
    .bus_data(bus_data), .addr_sel(addr_sel), .sys_clk_sel(sys_clk_sel),
    .in_fmt(in_fmt), .quick_mute(quick_mute), .power_on(power_on),
    .deemph(deemph), .vol_flat(vol_flat), .subvol_flat(subvol_flat),
    .mute_vec(mute_vec), .silence_vec(silence_vec), .invert_vec(invert_vec)
  );

  int checks = 0, fails = 0;
  bit done = 0, cmp_en = 0;

  // behavioural reference model
  bit m_sel = 0, m_all = 1;
  int m_type = 1, m_ptr = 0;
  int m_clk = 0, m_fmt = 0, m_qm = 0, m_pwr = 1, m_de = 0;
  int m_vol[NCH], m_sub[NCH], m_mute[NCH], m_sil[NCH], m_inv[NCH];

  task automatic m_defaults();
    m_qm = 0; m_pwr = 1; m_de = 0;
    for (int c = 0; c < NCH; c++) begin
      m_vol[c] = 0; m_sub[c] = 0; m_mute[c] = 0; m_sil[c] = 1; m_inv[c] = 0;
    end
  endtask

  task automatic model_byte(input bit addr_phase, input logic [7:0] b);
    if (addr_phase) begin
      m_sel = (b[7:2] == {5'b00010, addr_sel});
      m_type = int'(b[1:0]);
      return;
    end
    if (!m_sel) return;
    if (m_type == 2) begin
      if (b[7] == 1'b0) begin
        if (b[6]) m_defaults();
        else begin m_clk = int'(b[5:4]); m_fmt = int'(b[3:1]); end
      end else if (b[6] == 1'b0) begin
        m_qm = int'(b[1]); m_pwr = int'(b[0]);
      end
    end else if (m_type == 0) begin
      if (b[7:6] == 2'b11) begin
        m_all = b[3]; m_ptr = int'(b[2:0]);
      end else begin
        if (b[7:6] == 2'b10 && m_all) m_de = int'(b[5:3]);
        for (int c = 0; c < NCH; c++) begin
          if (m_all || m_ptr == c) begin
            case (b[7:6])
              2'b00: m_vol[c] = int'(b[5:0]);
              2'b01: m_sub[c] = int'(b[1:0]);
              default: begin m_mute[c] = int'(b[2]); m_sil[c] = int'(b[1]); m_inv[c] = int'(b[0]); end
            endcase
          end
        end
      end
    end
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // per-clock comparison against the model (R4 timing)
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      bit bad = 0;
      checks++;
      if (int'(sys_clk_sel) != m_clk || int'(in_fmt) != m_fmt) begin
        bad = 1; $display("FAIL R4/R6 clk=%0d fmt=%0d expected %0d %0d", sys_clk_sel, in_fmt, m_clk, m_fmt);
      end
      if (int'(quick_mute) != m_qm || int'(power_on) != m_pwr) begin
        bad = 1; $display("FAIL R4/R7 qm=%0d pwr=%0d expected %0d %0d", quick_mute, power_on, m_qm, m_pwr);
      end
      if (int'(deemph) != m_de) begin
        bad = 1; $display("FAIL R4/R10 deemph=%0d expected %0d", deemph, m_de);
      end
      for (int c = 0; c < NCH; c++) begin
        if (int'(vol_flat[c*6 +: 6]) != m_vol[c] || int'(subvol_flat[c*2 +: 2]) != m_sub[c]) begin
          bad = 1; $display("FAIL R4/R9 ch%0d vol=%0d sub=%0d expected %0d %0d", c,
                            vol_flat[c*6 +: 6], subvol_flat[c*2 +: 2], m_vol[c], m_sub[c]);
        end
        if (int'(mute_vec[c]) != m_mute[c] || int'(silence_vec[c]) != m_sil[c] || int'(invert_vec[c]) != m_inv[c]) begin
          bad = 1; $display("FAIL R4/R10 ch%0d flags=%0d%0d%0d expected %0d%0d%0d", c,
                            mute_vec[c], silence_vec[c], invert_vec[c], m_mute[c], m_sil[c], m_inv[c]);
        end
      end
      if (bad) fails++;
    end
  end

  task automatic send_byte(input logic md, input logic [7:0] b);
    @(negedge clk); bus_mode = 1'b0;
    repeat (2) @(negedge clk);
    bus_mode = md;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); bus_clk = 1'b0; bus_data = b[i];
      repeat (2) @(negedge clk);
      bus_clk = 1'b1;
      if (i < 7) repeat (2) @(negedge clk);
    end
    repeat (4) @(posedge clk);
    #1 model_byte(!md, b);
    @(negedge clk);
  endtask

  task automatic send_partial(input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); bus_clk = 1'b0; bus_data = 1'b1;
      repeat (2) @(negedge clk);
      bus_clk = 1'b1;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R4 watchdog expired got=hang expected=completion");
      finish_run();
    end
  end

  initial begin
    m_defaults();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1;
    // R13 reset state
    chk("R13 power_on", int'(power_on), 1);
    chk("R13 sys_clk_sel", int'(sys_clk_sel), 0);
    chk("R13 silence_vec", int'(silence_vec), 63);
    chk("R13 vol_flat", int'(vol_flat), 0);
    // R6 status clock/format, R1 address accepted
    send_byte(1'b0, 8'h12);
    send_byte(1'b1, 8'h26);
    chk("R6 sys_clk_sel", int'(sys_clk_sel), 2);
    chk("R1 in_fmt after address", int'(in_fmt), 3);
    // R7 quick mute and power
    send_byte(1'b1, 8'h83);
    chk("R7 quick_mute", int'(quick_mute), 1);
    send_byte(1'b1, 8'h80);
    chk("R7 power_on", int'(power_on), 0);
    send_byte(1'b1, 8'hC3);
    chk("R7 field 11 ignored", int'(power_on), 0);
    // R11 pointer, R9 volume/sub, R10 flags
    send_byte(1'b0, 8'h10);
    send_byte(1'b1, 8'hC2);
    send_byte(1'b1, 8'h0C);
    chk("R11 ch3 volume", int'(vol_flat[17:12]), 12);
    chk("R11 ch1 untouched", int'(vol_flat[5:0]), 0);
    send_byte(1'b1, 8'h43);
    chk("R9 ch3 sub", int'(subvol_flat[5:4]), 3);
    send_byte(1'b1, 8'hAD);
    chk("R10 mute_vec", int'(mute_vec), 4);
    chk("R10 silence_vec", int'(silence_vec), 59);
    chk("R10 deemph held without broadcast", int'(deemph), 0);
    // broadcast
    send_byte(1'b1, 8'hC8);
    send_byte(1'b1, 8'h05);
    chk("R4 selection persists, ch6 volume", int'(vol_flat[35:30]), 5);
    send_byte(1'b1, 8'h9A);
    chk("R10 deemph broadcast", int'(deemph), 3);
    chk("R10 invert cleared", int'(invert_vec), 0);
    // R12 unused pointer
    send_byte(1'b1, 8'hC6);
    send_byte(1'b1, 8'h3F);
    chk("R12 vol unchanged", int'(vol_flat[5:0]), 5);
    send_byte(1'b1, 8'hA7);
    chk("R12 invert unchanged", int'(invert_vec), 0);
    // R2 reserved types
    send_byte(1'b0, 8'h11);
    send_byte(1'b1, 8'h07);
    send_byte(1'b0, 8'h13);
    send_byte(1'b1, 8'h83);
    chk("R2 reserved type ignored", int'(power_on), 0);
    chk("R2 reserved type qm", int'(quick_mute), 0);
    // R3 identity
    send_byte(1'b0, 8'h10);
    send_byte(1'b1, 8'hC8);
    send_byte(1'b0, 8'h14);
    send_byte(1'b1, 8'h0A);
    chk("R3 deselected write ignored", int'(vol_flat[5:0]), 5);
    addr_sel = 1'b1;
    repeat (6) @(negedge clk);
    send_byte(1'b0, 8'h14);
    send_byte(1'b1, 8'h0A);
    chk("R3 alternate identity accepted", int'(vol_flat[5:0]), 10);
    // R5 partial byte dropped
    send_partial(3);
    send_byte(1'b1, 8'h41);
    chk("R5 sub after partial", int'(subvol_flat[9:8]), 1);
    chk("R5 vol after partial", int'(vol_flat[29:24]), 10);
    // R8 soft reset
    send_byte(1'b0, 8'h16);
    send_byte(1'b1, 8'h82);
    send_byte(1'b1, 8'h40);
    chk("R8 quick_mute default", int'(quick_mute), 0);
    chk("R8 power default", int'(power_on), 1);
    chk("R8 vol default", int'(vol_flat), 0);
    chk("R8 deemph default", int'(deemph), 0);
    chk("R8 clock kept", int'(sys_clk_sel), 2);
    chk("R8 format kept", int'(in_fmt), 3);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule